// File: doc/BRIEF.md
# Byte Stack Pointer Unit

This block keeps a 10-bit stack pointer into data SRAM and drives the SRAM address and strobes for stack traffic. A sequencer outside the block places an operation code on its input. The block then stores or fetches one data byte, or it stores or fetches a 16-bit return address over two consecutive cycles. The stack grows downward. Firmware loads the pointer, usually with the highest RAM address, through two byte-wide register writes, and it can read the pointer back the same way.

A byte operation takes one cycle. A return-address operation takes two cycles, and `busy` is high during the second one. The SRAM is read combinationally. Each transfer has guard limits: an upper bound at the top of RAM and a lower bound that keeps the stack out of the register area below address 0x60. A transfer that would cross a limit does not take place and raises a one-cycle error pulse.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer is 0, `busy` and `stackErr` are low, and `spLo` and `spHi` read 0.
- R2: When `ioWrLo` is high, `ioWrData` is loaded into pointer bits 7:0. When `ioWrHi` is high, `ioWrData[1:0]` is loaded into pointer bits 9:8, and `ioWrData[7:2]` is ignored. `spHi` reads the upper pointer bits zero-extended to 8 bits. A load takes effect at the next clock edge.
- R3: Operation code 1 is a byte push. In the same cycle it writes `dataIn` to the address held in the pointer, and the pointer then drops by 1.
- R4: Operation code 2 is a byte pop. It reads the address equal to the pointer plus 1, and the pointer rises by 1. `dataOut` holds the byte after the edge.
- R5: Operation code 3 is a return-address push. In the first cycle it writes `retIn[7:0]` at the pointer. In the second cycle it writes `retIn[15:8]` at the pointer minus 1. The pointer drops by 2 in total. `busy` is high in the second cycle, and any operation code presented during that cycle is ignored.
- R6: Operation codes 4 and 5 are return-address pops. The first cycle reads the pointer plus 1 into `retOut[15:8]`. The second cycle reads the next higher address into `retOut[7:0]`. The pointer rises by 2 in total.
- R7: A push is refused when any address it would write lies below 0x60. A pop is refused when any address it would read lies above the top address 0x25F. A refused operation produces no SRAM strobe and leaves the pointer unchanged, and `stackErr` is high for the one cycle after it. Because the pointer resets to 0, every push made before firmware loads the pointer is refused.
- R8: A pointer register write in an idle cycle takes priority over an operation code presented in the same cycle. That operation is dropped, with no strobe and no error. A pointer register write that arrives while `busy` is high is ignored.
- R9: Operation codes 0, 6 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op | input | 3 | Stack operation code |
| dataIn | input | 8 | Byte to push |
| retIn | input | 16 | Return address to push |
| ioWrLo | input | 1 | Write strobe for the low pointer byte |
| ioWrHi | input | 1 | Write strobe for the high pointer byte |
| ioWrData | input | 8 | Pointer register write data |
| spLo | output | 8 | Pointer bits 7:0 |
| spHi | output | 8 | Pointer upper bits, zero-extended |
| dataOut | output | 8 | Last popped byte |
| retOut | output | 16 | Last popped return address |
| busy | output | 1 | Second cycle of a return-address operation |
| stackErr | output | 1 | Pulse one cycle after a refused operation |
| memAddr | output | 10 | SRAM address |
| memWe | output | 1 | SRAM write strobe |
| memWdata | output | 8 | SRAM write data |
| memRe | output | 1 | SRAM read strobe |
| memRdata | input | 8 | SRAM read data, combinational |

## Verification
Two functions can land in the same cycle. The first pair is a pointer register write and a stack operation code, either in an idle cycle or in the second half of a return-address transfer. The random stimulus raises the register write strobes on a few percent of cycles while operation codes keep flowing, so both cases occur. Directed cycles also force each case. A cycle-accurate bench model judges each of these cycles by the pointer it then reads back and by the strobes it sees. The second pair is a limit refusal and an operation. To provoke it, the pointer is reloaded near 0x60 and near the top of RAM.

// File: rtl/stack_pkg.sv
`timescale 1ns/1ps
package stack_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0, OP_PUSHB = 3'd1, OP_POPB = 3'd2,
    OP_CALL = 3'd3, OP_RET = 3'd4, OP_RETI = 3'd5
  } stackOp_e;

  typedef enum logic [1:0] {ST_IDLE, ST_PUSH2, ST_POP2} stackState_e;

  typedef struct packed {
    logic spDec;
    logic spInc;
    logic memWe;
    logic memRe;
    logic addrUp;     // address pointer+1 instead of pointer
    logic holdLoad;   // write retIn low byte, keep high byte
    logic wrSelHold;  // write the kept high byte
    logic capData;
    logic capRetHi;
    logic capRetLo;
    logic ioLo;
    logic ioHi;
  } ctrlStrobe_t;
endpackage

// File: rtl/stack_ctrl.sv
`timescale 1ns/1ps
module stack_ctrl
  import stack_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int FLOOR   = 32'h60,
  parameter int RAM_TOP = 32'h25F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op,
  input  logic              ioWrLo,
  input  logic              ioWrHi,
  input  logic [ADDR_W-1:0] sp,
  output ctrlStrobe_t       ctrl,
  output logic              busy,
  output logic              stackErr
);
  localparam logic [ADDR_W:0] FloorW = (ADDR_W+1)'(FLOOR);
  localparam logic [ADDR_W:0] TopW   = (ADDR_W+1)'(RAM_TOP);

  stackState_e state, nextState;
  logic refuse;
  logic [ADDR_W:0] spW;
  logic pushOk1, pushOk2, popOk1, popOk2;

  assign spW     = {1'b0, sp};
  assign pushOk1 = spW >= FloorW;
  assign pushOk2 = spW >= FloorW + 1'b1;
  assign popOk1  = spW + 1'b1 <= TopW;
  assign popOk2  = spW + 2'd2 <= TopW;

  always_comb begin
    ctrl      = '0;
    nextState = state;
    refuse    = 1'b0;
    unique case (state)
      ST_PUSH2: begin
        ctrl.memWe = 1'b1; ctrl.wrSelHold = 1'b1; ctrl.spDec = 1'b1;
        nextState = ST_IDLE;
      end
      ST_POP2: begin
        ctrl.memRe = 1'b1; ctrl.addrUp = 1'b1; ctrl.capRetLo = 1'b1;
        ctrl.spInc = 1'b1;
        nextState = ST_IDLE;
      end
      default: begin
        if (ioWrLo || ioWrHi) begin
          ctrl.ioLo = ioWrLo;
          ctrl.ioHi = ioWrHi;
        end else begin
          case (op)
            OP_PUSHB:
              if (pushOk1) begin ctrl.memWe = 1'b1; ctrl.spDec = 1'b1; end
              else refuse = 1'b1;
            OP_POPB:
              if (popOk1) begin
                ctrl.memRe = 1'b1; ctrl.addrUp = 1'b1; ctrl.capData = 1'b1;
                ctrl.spInc = 1'b1;
              end else refuse = 1'b1;
            OP_CALL:
              if (pushOk2) begin
                ctrl.memWe = 1'b1; ctrl.holdLoad = 1'b1; ctrl.spDec = 1'b1;
                nextState = ST_PUSH2;
              end else refuse = 1'b1;
            OP_RET, OP_RETI:
              if (popOk2) begin
                ctrl.memRe = 1'b1; ctrl.addrUp = 1'b1; ctrl.capRetHi = 1'b1;
                ctrl.spInc = 1'b1;
                nextState = ST_POP2;
              end else refuse = 1'b1;
            default: ;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      stackErr <= 1'b0;
    end else begin
      state    <= nextState;
      stackErr <= refuse;
    end
  end

  assign busy = (state != ST_IDLE);

  // R5: a two-cycle transfer never stretches beyond its second cycle
  a_r5_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  // R3: read and write strobes are never raised together
  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl.memWe && ctrl.memRe));
  // R8: register writes are never applied during the second half
  a_r8_no_io_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(ctrl.ioLo || ctrl.ioHi));
endmodule

// File: rtl/stack_dp.sv
`timescale 1ns/1ps
module stack_dp
  import stack_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       ctrl,
  input  logic [7:0]        dataIn,
  input  logic [15:0]       retIn,
  input  logic [7:0]        ioWrData,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [7:0]        dataOut,
  output logic [15:0]       retOut
);
  localparam int HI_W = ADDR_W - 8;

  logic [7:0] holdHi;

  assign memAddr  = ctrl.addrUp ? sp + 1'b1 : sp;
  assign memWdata = ctrl.wrSelHold ? holdHi :
                    ctrl.holdLoad  ? retIn[7:0] : dataIn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp      <= '0;
      holdHi  <= '0;
      dataOut <= '0;
      retOut  <= '0;
    end else begin
      if (ctrl.spDec) sp <= sp - 1'b1;
      else if (ctrl.spInc) sp <= sp + 1'b1;
      else begin
        if (ctrl.ioLo) sp[7:0] <= ioWrData;
        if (ctrl.ioHi) sp[ADDR_W-1:8] <= ioWrData[HI_W-1:0];
      end
      if (ctrl.holdLoad) holdHi <= retIn[15:8];
      if (ctrl.capData)  dataOut <= memRdata;
      if (ctrl.capRetHi) retOut[15:8] <= memRdata;
      if (ctrl.capRetLo) retOut[7:0] <= memRdata;
    end
  end

  // R5: the high byte lands one address below the low byte
  a_r5_push_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.memWe && ctrl.wrSelHold) |-> memAddr == $past(memAddr) - 1'b1);
  // R6: the low byte is fetched one address above the high byte
  a_r6_pop_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.capRetLo |-> memAddr == $past(memAddr) + 1'b1);
endmodule

// File: rtl/stack_ptr_unit.sv
`timescale 1ns/1ps
module stack_ptr_unit
  import stack_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int FLOOR   = 32'h60,
  parameter int RAM_TOP = 32'h25F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op,
  input  logic [7:0]        dataIn,
  input  logic [15:0]       retIn,
  input  logic              ioWrLo,
  input  logic              ioWrHi,
  input  logic [7:0]        ioWrData,
  output logic [7:0]        spLo,
  output logic [7:0]        spHi,
  output logic [7:0]        dataOut,
  output logic [15:0]       retOut,
  output logic              busy,
  output logic              stackErr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [7:0]        memWdata,
  output logic              memRe,
  input  logic [7:0]        memRdata
);
  localparam int HI_W = ADDR_W - 8;

  ctrlStrobe_t ctrl;
  logic [ADDR_W-1:0] sp;

  stack_ctrl #(.ADDR_W(ADDR_W), .FLOOR(FLOOR), .RAM_TOP(RAM_TOP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op(op), .ioWrLo(ioWrLo), .ioWrHi(ioWrHi),
    .sp(sp), .ctrl(ctrl), .busy(busy), .stackErr(stackErr));

  stack_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .dataIn(dataIn), .retIn(retIn),
    .ioWrData(ioWrData), .memRdata(memRdata), .sp(sp), .memAddr(memAddr),
    .memWdata(memWdata), .dataOut(dataOut), .retOut(retOut));

  assign memWe = ctrl.memWe;
  assign memRe = ctrl.memRe;
  assign spLo  = sp[7:0];
  assign spHi  = {{(8-HI_W){1'b0}}, sp[ADDR_W-1:8]};

  // R7: no write below the floor, no read above the top
  a_r7_floor: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> int'(memAddr) >= FLOOR);
  a_r7_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    memRe |-> int'(memAddr) <= RAM_TOP);
  // R7: a refused operation left the pointer where it was
  a_r7_err_holds_sp: assert property (@(posedge clk) disable iff (!rst_n)
    stackErr |-> (spLo == $past(spLo) && spHi == $past(spHi)));
endmodule

// File: tb/tb_stack_ptr_unit.sv
`timescale 1ns/1ps
module tb_stack_ptr_unit;
  localparam int FLOOR = 32'h60;
  localparam int TOP   = 32'h25F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] dataIn = '0, ioWrData = '0;
  logic [15:0] retIn = '0;
  logic ioWrLo = 1'b0, ioWrHi = 1'b0;
  logic [7:0] spLo, spHi, dataOut, memWdata, memRdata;
  logic [15:0] retOut;
  logic busy, stackErr, memWe, memRe;
  logic [9:0] memAddr;
  logic [7:0] sram [0:1023];

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // bench model state
  int mSp = 0, mPhase = 0, mHold = 0, mData = 0, mRet = 0;
  bit mErr = 0;
  int refMem [0:1023];

  always #2 clk = ~clk;

  stack_ptr_unit dut (
    .clk(clk), .rst_n(rst_n), .op(op), .dataIn(dataIn), .retIn(retIn),
    .ioWrLo(ioWrLo), .ioWrHi(ioWrHi), .ioWrData(ioWrData), .spLo(spLo),
    .spHi(spHi), .dataOut(dataOut), .retOut(retOut), .busy(busy),
    .stackErr(stackErr), .memAddr(memAddr), .memWe(memWe),
    .memWdata(memWdata), .memRe(memRe), .memRdata(memRdata));

  always @(posedge clk) if (memWe) sram[memAddr] <= memWdata;
  assign memRdata = sram[memAddr];

  task automatic check(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, check strobes, check state at next negedge
  task automatic cycle(int o, int din, int ret, bit wlo, bit whi, int wd);
    string tag;
    bit eWe = 0, eRe = 0;
    int eAddr = 0, eWd = 0;
    op = 3'(o); dataIn = 8'(din); retIn = 16'(ret);
    ioWrLo = wlo; ioWrHi = whi; ioWrData = 8'(wd);
    mErr = 0;
    if (mPhase == 1) begin
      tag = "R5"; eWe = 1; eAddr = mSp; eWd = mHold;
      refMem[mSp] = mHold; mSp--; mPhase = 0;
    end else if (mPhase == 2) begin
      tag = "R6"; eRe = 1; eAddr = mSp + 1;
      mRet = (mRet & 16'hFF00) | refMem[mSp + 1]; mSp++; mPhase = 0;
    end else if (wlo || whi) begin
      tag = (o != 0) ? "R8" : "R2";
      if (wlo) mSp = (mSp & 10'h300) | (wd & 8'hFF);
      if (whi) mSp = (mSp & 10'h0FF) | ((wd & 3) << 8);
    end else begin
      case (o)
        1: begin tag = "R3";
          if (mSp >= FLOOR) begin
            eWe = 1; eAddr = mSp; eWd = din & 8'hFF; refMem[mSp] = eWd; mSp--;
          end else begin mErr = 1; tag = "R7"; end
        end
        2: begin tag = "R4";
          if (mSp + 1 <= TOP) begin
            eRe = 1; eAddr = mSp + 1; mData = refMem[mSp + 1]; mSp++;
          end else begin mErr = 1; tag = "R7"; end
        end
        3: begin tag = "R5";
          if (mSp >= FLOOR + 1) begin
            eWe = 1; eAddr = mSp; eWd = ret & 8'hFF; refMem[mSp] = eWd;
            mHold = (ret >> 8) & 8'hFF; mSp--; mPhase = 1;
          end else begin mErr = 1; tag = "R7"; end
        end
        4, 5: begin tag = "R6";
          if (mSp + 2 <= TOP) begin
            eRe = 1; eAddr = mSp + 1;
            mRet = (mRet & 16'h00FF) | (refMem[mSp + 1] << 8); mSp++; mPhase = 2;
          end else begin mErr = 1; tag = "R7"; end
        end
        default: tag = "R9";
      endcase
    end
    #1;
    check(tag, "memWe", int'(memWe), int'(eWe));
    check(tag, "memRe", int'(memRe), int'(eRe));
    if (eWe || eRe) check(tag, "memAddr", int'(memAddr), eAddr);
    if (eWe) check(tag, "memWdata", int'(memWdata), eWd);
    @(negedge clk);
    check(tag, "pointer", int'({spHi, spLo}), mSp);
    check(tag, "stackErr", int'(stackErr), int'(mErr));
    check(tag, "busy", int'(busy), int'(mPhase != 0));
    check(tag, "dataOut", int'(dataOut), mData);
    check(tag, "retOut", int'(retOut), mRet);
  endtask

  task automatic loadSp(int v);
    cycle(0, 0, 0, 1, 1, 0);            // clear first
    cycle(0, 0, 0, 1, 0, v & 8'hFF);
    cycle(0, 0, 0, 0, 1, (v >> 8) | 8'hFC); // R2: upper data bits ignored
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin sram[i] = 8'h00; refMem[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "spLo", int'(spLo), 0);
    check("R1", "spHi", int'(spHi), 0);
    check("R1", "busy", int'(busy), 0);
    check("R1", "stackErr", int'(stackErr), 0);
    // R7: pushes before initialisation are refused
    cycle(1, 8'hAA, 0, 0, 0, 0);
    cycle(3, 0, 16'h1234, 0, 0, 0);
    // sequence from a mid-RAM pointer
    loadSp(16'h100);
    cycle(3, 0, 16'h1234, 0, 0, 0);
    cycle(2, 0, 0, 0, 0, 0);            // R5: ignored while busy
    cycle(3, 0, 16'h4567, 0, 0, 0);
    cycle(0, 0, 0, 1, 1, 8'h77);        // R8: register write ignored while busy
    cycle(5, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0);
    check("R6", "retOut after pop", int'(retOut), 16'h4567);
    check("R6", "pointer after pop", int'({spHi, spLo}), 16'hFE);
    cycle(1, 8'h5A, 0, 0, 0, 0);
    cycle(2, 0, 0, 0, 0, 0);
    check("R4", "dataOut", int'(dataOut), 8'h5A);
    // R8: register write and operation in the same idle cycle
    cycle(1, 8'h11, 0, 1, 0, 8'h80);
    cycle(6, 0, 0, 0, 0, 0);
    cycle(7, 0, 0, 0, 0, 0);
    // R7 boundaries at the floor and the top
    loadSp(FLOOR);
    cycle(3, 0, 16'hBEEF, 0, 0, 0);
    cycle(1, 8'h33, 0, 0, 0, 0);
    cycle(1, 8'h44, 0, 0, 0, 0);
    loadSp(TOP - 1);
    cycle(4, 0, 0, 0, 0, 0);
    cycle(2, 0, 0, 0, 0, 0);
    cycle(2, 0, 0, 0, 0, 0);
    // constrained random with a fixed seed
    void'($urandom(32'd7763));
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      if (n % 150 == 0) begin
        int pick = $urandom_range(0, 2);
        loadSp(pick == 0 ? FLOOR - 2 + $urandom_range(0, 12) :
               pick == 1 ? TOP - 10 + $urandom_range(0, 12) :
                           $urandom_range(FLOOR, TOP));
      end else if (r < 4)
        cycle($urandom_range(0, 7), 0, 0, 1'($urandom), 1'($urandom), $urandom_range(0, 255));
      else
        cycle($urandom_range(0, 7), $urandom_range(0, 255), $urandom_range(0, 65535), 0, 0, 0);
    end
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule